// File: doc/BRIEF.md
# Unconditional Immediate Branch Target Generator

This block works out where an unconditional immediate branch goes. Each cycle it may accept one 32-bit instruction word together with the address the instruction was fetched from. When the word is an unconditional immediate branch, the block registers the 32-bit target address. When the branch is a linking form, it also registers a flag and the return address. Results appear one clock after the input is presented.

The 24-bit immediate field is shifted left by two places to give a signed 26-bit byte displacement, which reaches 32 MB either way. The absolute bit picks the base. When it is clear, the base is the address of the branch itself. When it is set, the base is zero, so a negative displacement lands near the top of the address space. All sums are taken modulo 2^32.

The fetch stage uses the block to redirect the stream as early as possible. Conditional branches, prediction and the redirect itself are left to other logic.

Top module: `bta_target_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_link` are 0 after that edge.
- R2: Instruction bits 31:26 (MSB numbering from bit 31) hold the opcode. Only opcode value 18 with `in_valid` high gives `out_valid` = 1 one cycle later. Any other opcode gives `out_valid` = 0.
- R3: With absolute bit (instruction bit 1) clear, `out_target` = `in_pc` + sign-extend({instr[25:2], 2'b00}), modulo 2^32.
- R4: With absolute bit set, `out_target` = sign-extend({instr[25:2], 2'b00}), independent of `in_pc`.
- R5: An absolute branch whose immediate field is all ones (displacement 0x3FFFFFC) gives target 0xFFFFFFFC.
- R6: With link bit (instruction bit 0) set on a valid branch, `out_link` = 1 and `out_ret_addr` = `in_pc` + 4 modulo 2^32. With it clear, `out_link` = 0. `out_link` is never 1 while `out_valid` is 0.
- R7: A cycle with `in_valid` low gives `out_valid` = 0 one cycle later.
- R8: Relative targets wrap at both ends of the address space: a positive displacement past 0xFFFFFFFF and a negative displacement below 0 each wrap modulo 2^32.
- R9: The largest displacements, +0x1FFFFFC and -0x2000000, are reached exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word and address are present |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the instruction |
| out_valid | output | 1 | Registered: a branch target is available |
| out_target | output | 32 | Registered branch target address |
| out_link | output | 1 | Registered: branch is a linking form |
| out_ret_addr | output | 32 | Registered return address (branch address + 4) |

## Verification
The only state in the block is one output register stage, so any internal fault shows at the ports on the very next clock. A wrong base select or sign extension gives a bad `out_target` for that one instruction. A decode fault either raises `out_valid` for a non-branch word or drops it for a real branch. The stimulus mixes absolute and relative forms, both signs, linking and plain forms, and addresses at both ends of the space, so that extension, base and carry faults each change at least one compared value.

// File: rtl/bta_pkg.sv
// Package: shared field layout for the branch target generator.
// Assumes a 32-bit instruction word with the opcode in the top six bits.
package bta_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int IMM_W   = 24;

    // Fields of an unconditional immediate branch, MSB first.
    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [IMM_W-1:0] imm;
        logic             absolute;
        logic             link;
    } br_word_t;
endpackage

// File: rtl/bta_decode.sv
// Module: bta_decode
// Splits an instruction word into branch fields and flags a valid
// unconditional immediate branch. Purely combinational.
// Assumes the field layout in bta_pkg::br_word_t.
module bta_decode
    import bta_pkg::*;
#(
    parameter logic [OPC_W-1:0] BR_OPCODE = 6'd18
) (
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               hit_o,
    output logic [IMM_W-1:0]   imm_o,
    output logic               absolute_o,
    output logic               link_o
);
    br_word_t word;

    // Overlay the field layout on the raw instruction word.
    always_comb begin
        word       = br_word_t'(instr_i);
        hit_o      = valid_i && (word.opcode == BR_OPCODE);
        imm_o      = word.imm;
        absolute_o = word.absolute;
        link_o     = word.link;
    end
endmodule

// File: rtl/bta_addr_calc.sv
// Module: bta_addr_calc
// Widens the word immediate to a byte displacement, sign-extends it and
// adds the selected base. All sums wrap modulo 2^ADDR_W.
// Assumes ADDR_W exceeds the displacement width (IMM_W + 2).
module bta_addr_calc #(
    parameter int ADDR_W    = 32,
    parameter int IMM_W     = 24,
    parameter int LINK_STEP = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              absolute_i,
    output logic [ADDR_W-1:0] target_o,
    output logic [ADDR_W-1:0] ret_addr_o
);
    localparam int DISP_W = IMM_W + 2;
    localparam int EXT_W  = ADDR_W - DISP_W;

    logic [DISP_W-1:0] disp;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] base;

    // Form the byte displacement and extend its sign to address width.
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb begin
                disp     = {imm_i, 2'b00};
                disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
            end
        end else begin : g_noext
            always_comb begin
                disp     = {imm_i, 2'b00};
                disp_ext = disp[ADDR_W-1:0];
            end
        end
    endgenerate

    // Pick the base and add; carry out of the top bit is dropped.
    always_comb begin
        base       = absolute_i ? '0 : pc_i;
        target_o   = base + disp_ext;
        ret_addr_o = pc_i + ADDR_W'(LINK_STEP);
    end
endmodule

// File: rtl/bta_target_gen.sv
// Module: bta_target_gen (top)
// Decodes an unconditional immediate branch, computes its target and
// return address, and registers the results one cycle later.
// Assumes synchronous active-low reset; data outputs reset to zero.
module bta_target_gen
    import bta_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter logic [OPC_W-1:0] BR_OPCODE = 6'd18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic [ADDR_W-1:0]  in_pc,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_target,
    output logic               out_link,
    output logic [ADDR_W-1:0]  out_ret_addr
);
    logic              hit;
    logic [IMM_W-1:0]  imm;
    logic              absolute;
    logic              link;
    logic [ADDR_W-1:0] target_c;
    logic [ADDR_W-1:0] ret_c;

    bta_decode #(.BR_OPCODE(BR_OPCODE)) u_decode (
        .valid_i    (in_valid),
        .instr_i    (in_instr),
        .hit_o      (hit),
        .imm_o      (imm),
        .absolute_o (absolute),
        .link_o     (link)
    );

    bta_addr_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .LINK_STEP(4)) u_calc (
        .pc_i       (in_pc),
        .imm_i      (imm),
        .absolute_i (absolute),
        .target_o   (target_c),
        .ret_addr_o (ret_c)
    );

    // Output stage: capture results of a hit, clear flags otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_link     <= 1'b0;
            out_target   <= '0;
            out_ret_addr <= '0;
        end else begin
            out_valid <= hit;
            out_link  <= hit && link;
            if (hit) begin
                out_target   <= target_c;
                out_ret_addr <= ret_c;
            end
        end
    end
endmodule

// File: rtl/bta_checker.sv
// Module: bta_checker
// Property checks for bta_target_gen, bound to every instance.
// Assumes the instruction field layout given in the brief.
module bta_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       in_instr,
    input logic [ADDR_W-1:0] in_pc,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_target,
    input logic              out_link,
    input logic [ADDR_W-1:0] out_ret_addr
);
    logic is_br;
    assign is_br = in_valid && (in_instr[31:26] == 6'd18);

    // R7: an idle input cycle leaves no result behind.
    a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: a non-branch opcode never yields a result.
    a_r2_other_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[31:26] != 6'd18) |=> !out_valid);

    // R2: a branch always yields a result.
    a_r2_branch_valid: assert property (@(posedge clk) disable iff (!rst_n)
        is_br |=> out_valid);

    // R6: link flag only with a valid result.
    a_r6_link_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        out_link |-> out_valid);

    // R6: return address is the branch address plus four.
    a_r6_ret_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && in_instr[0]) |=> (out_link && out_ret_addr == $past(in_pc) + ADDR_W'(4)));

    // R3: relative targets keep the low two bits of the branch address.
    a_r3_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && !in_instr[1]) |=> (out_target[1:0] == $past(in_pc[1:0])));

    // R4: absolute targets ignore the branch address and are word aligned.
    a_r4_abs_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && in_instr[1]) |=> (out_target[1:0] == 2'b00));

    // R1: flags are clear after a reset edge.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_link));
endmodule

bind bta_target_gen bta_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_instr     (in_instr),
    .in_pc        (in_pc),
    .out_valid    (out_valid),
    .out_target   (out_target),
    .out_link     (out_link),
    .out_ret_addr (out_ret_addr)
);

// File: tb/bta_target_gen_tb.sv
// Bench for bta_target_gen: behavioural reference compared on every clock.
module bta_target_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic        out_valid;
    logic [31:0] out_target;
    logic        out_link;
    logic [31:0] out_ret_addr;

    int checks = 0;
    int errors = 0;

    // Reference expectations for the next sampled cycle.
    logic        e_valid = 1'b0;
    logic        e_link = 1'b0;
    logic [31:0] e_target = '0;
    logic [31:0] e_ret = '0;
    string       e_tag = "R1";

    always #2 clk = ~clk; // 250 MHz

    bta_target_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_pc(in_pc), .out_valid(out_valid), .out_target(out_target),
        .out_link(out_link), .out_ret_addr(out_ret_addr)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare outputs against the reference for the previous cycle.
    task automatic compare();
        check(e_tag, "out_valid", {31'd0, out_valid}, {31'd0, e_valid});
        check(e_valid ? "R6" : e_tag, "out_link", {31'd0, out_link}, {31'd0, e_link});
        if (e_valid) begin
            check(e_tag, "out_target", out_target, e_target);
            if (e_link) check("R6", "out_ret_addr", out_ret_addr, e_ret);
        end
    endtask

    // One cycle: check last result, then drive and model a new input.
    task automatic step(input logic v, input logic [31:0] instr,
                        input logic [31:0] pc, input string tag);
        int d;
        @(negedge clk);
        compare();
        in_valid = v;
        in_instr = instr;
        in_pc    = pc;
        d = $signed({instr[25:2], 2'b00});
        e_valid  = rst_n && v && (instr[31:26] == 6'd18);
        e_link   = e_valid && instr[0];
        e_target = instr[1] ? 32'(d) : pc + 32'(d);
        e_ret    = pc + 32'd4;
        e_tag    = tag;
    endtask

    function automatic logic [31:0] br(input logic [23:0] imm, input logic aa,
                                       input logic lk);
        return {6'd18, imm, aa, lk};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset holds flags low even with a branch presented.
        step(1'b1, br(24'h000010, 1'b0, 1'b1), 32'h1000, "R1");
        step(1'b1, br(24'h000010, 1'b0, 1'b1), 32'h1000, "R1");
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        e_valid = 1'b0; e_link = 1'b0; e_tag = "R1";
        in_valid = 1'b0;
        step(1'b0, '0, '0, "R7");
        // R3: relative forward and backward.
        step(1'b1, br(24'h000040, 1'b0, 1'b0), 32'h0000_2000, "R3");
        step(1'b1, br(24'hFFFFF0, 1'b0, 1'b0), 32'h0000_2000, "R3");
        // R4: absolute positive, address ignored.
        step(1'b1, br(24'h000123, 1'b1, 1'b0), 32'h8765_4320, "R4");
        // R5: absolute all-ones immediate wraps to top of memory.
        step(1'b1, br(24'hFFFFFF, 1'b1, 1'b0), 32'h0000_1000, "R5");
        // R6: linking relative and linking absolute.
        step(1'b1, br(24'h000008, 1'b0, 1'b1), 32'h0040_0000, "R6");
        step(1'b1, br(24'hFFFFFE, 1'b1, 1'b1), 32'h1234_5678, "R6");
        step(1'b1, br(24'h000001, 1'b0, 1'b1), 32'hFFFF_FFFC, "R6");
        // R2: other opcodes give no result.
        step(1'b1, {6'd16, 24'h000010, 2'b01}, 32'h100, "R2");
        step(1'b1, {6'd19, 24'h000010, 2'b11}, 32'h100, "R2");
        // R7: valid low with a branch word on the bus.
        step(1'b0, br(24'h000010, 1'b0, 1'b1), 32'h100, "R7");
        // R8: wrap past the top and below zero.
        step(1'b1, br(24'h000008, 1'b0, 1'b0), 32'hFFFF_FFF0, "R8");
        step(1'b1, br(24'hFFFFFC, 1'b0, 1'b0), 32'h0000_0008, "R8");
        // R9: range extremes, relative and absolute.
        step(1'b1, br(24'h7FFFFF, 1'b0, 1'b0), 32'h1000_0000, "R9");
        step(1'b1, br(24'h800000, 1'b0, 1'b0), 32'h1000_0000, "R9");
        step(1'b1, br(24'h7FFFFF, 1'b1, 1'b0), 32'h0, "R9");
        step(1'b1, br(24'h800000, 1'b1, 1'b1), 32'h0, "R9");
        step(1'b0, '0, '0, "R7");
        step(1'b0, '0, '0, "R7");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule